// File: doc/BRIEF.md
# Floating-point status and control register

This block holds the 32-bit status and control word of a floating-point unit. A register-bus write stores the incoming word through a fixed mask. The same write splits out three configuration fields: the vector length, the vector stride and the rounding mode. The rounding mode, the trap-enable field and the vector fields are driven as outputs to the arithmetic datapath.

Sticky exception inputs from the arithmetic unit build up in a separate flag set. A full read of the control word merges the vector fields back into their slots and ORs in the cumulative flags. A compare port takes the outcome of a floating-point comparison and rewrites only the four condition bits at the top of the word. A condition-only read returns just those four bits, for transfer into an integer status register. A second, read-only register returns a constant identification word.

Top module: `fpsr_ctrl`

## Requirements
- R1: After reset, the control register, the sticky flags and all field outputs read zero.
- R2: A control write (`wr_en_i`=1, `wr_sel_i`=1) stores `wr_data_i & 32'hFFC8FFFF`. It also captures the vector length from bits 18:16 and the vector stride from bits 21:20. These drive `vec_len_o` and `vec_stride_o` from the next cycle on.
- R3: A control read (`rd_sel_i`=1) returns the stored masked word with the length merged at bits 18:16 and the stride at bits 21:20, and with the sticky flags ORed into bits 4:0.
- R4: `round_mode_o` follows stored bits 23:22, encoded as 0 to nearest, 1 toward plus infinity, 2 toward minus infinity and 3 toward zero.
- R5: `trap_en_o` follows stored bits 12:8, in the same bit order as the exception flags.
- R6: `exc_set_i` bits are invalid (0), divide-by-zero (1), overflow (2), underflow (3) and inexact (4). A pulse on a bit sets the matching flag. The flag holds until the next control write clears it.
- R7: A compare update (`cmp_valid_i`) writes bits 31:28 according to `cmp_res_i`: 0 equal gives 4'b1100, 1 less gives 4'b1000, 2 greater gives 4'b0010, and 3 unordered gives 4'b0011. Bits 27:0 are left unchanged.
- R8: A condition-only read (`rd_sel_i`=2) returns the control word ANDed with 32'hF0000000.
- R9: The identification read (`rd_sel_i`=0) always returns `IDENT_VAL`. A write with `wr_sel_i`=0 changes no state.
- R10: When a control write coincides with a compare update or an exception pulse, the write alone determines the next state.
- R11: `rd_sel_i`=3 returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 identification, 1 control |
| wr_data_i | input | 32 | Write data |
| rd_sel_i | input | 2 | Read view: 0 ident, 1 control, 2 condition, 3 none |
| rd_data_o | output | 32 | Read data, combinational |
| exc_set_i | input | 5 | Exception pulses from the arithmetic unit |
| cmp_valid_i | input | 1 | Compare outcome valid |
| cmp_res_i | input | 2 | Compare outcome code |
| round_mode_o | output | 2 | Rounding mode field |
| trap_en_o | output | 5 | Trap-enable field |
| vec_len_o | output | 3 | Vector length field |
| vec_stride_o | output | 2 | Vector stride field |

## Verification
The bench builds the block with a non-default `IDENT_VAL` of 32'h5A10_0C31, so a stuck or swapped identification word is visible. Its writes cover every combination of vector length, stride and rounding mode. It sets all 31 non-empty sticky-flag patterns and drives all four compare outcomes over a known lower word. With the 5-bit flag width, every flag pattern and every overlap between a write and a flag pulse or compare update falls within a short run.

// File: rtl/fpsr_pkg.sv
`timescale 1ns/1ps
package fpsr_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned EXC_W    = 5;
  localparam int unsigned LEN_LSB  = 16;
  localparam int unsigned LEN_W    = 3;
  localparam int unsigned STR_LSB  = 20;
  localparam int unsigned STR_W    = 2;
  localparam int unsigned RM_LSB   = 22;
  localparam int unsigned RM_W     = 2;
  localparam int unsigned TRAP_LSB = 8;
  localparam int unsigned COND_LSB = 28;
  localparam int unsigned COND_W   = 4;
  localparam logic [REG_W-1:0] WR_MASK   = 32'hFFC8_FFFF;
  localparam logic [REG_W-1:0] COND_MASK = 32'hF000_0000;

  typedef enum logic [1:0] {
    CMP_EQ = 2'd0, CMP_LT = 2'd1, CMP_GT = 2'd2, CMP_UN = 2'd3
  } cmp_res_e;

  typedef enum logic [1:0] {
    RD_IDENT = 2'd0, RD_CTRL = 2'd1, RD_COND = 2'd2, RD_NONE = 2'd3
  } rd_sel_e;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'd0, RM_POS_INF = 2'd1, RM_NEG_INF = 2'd2, RM_ZERO = 2'd3
  } round_mode_e;
endpackage

// File: rtl/fpsr_cond_enc.sv
`timescale 1ns/1ps
module fpsr_cond_enc
  import fpsr_pkg::*;
(
  input  logic [1:0]        res_i,
  output logic [COND_W-1:0] cond_o
);
  cmp_res_e res;
  assign res = cmp_res_e'(res_i);

  always_comb begin
    unique case (res)
      CMP_EQ:  cond_o = 4'b1100;
      CMP_LT:  cond_o = 4'b1000;
      CMP_GT:  cond_o = 4'b0010;
      default: cond_o = 4'b0011;
    endcase
  end
endmodule

// File: rtl/fpsr_sticky.sv
`timescale 1ns/1ps
module fpsr_sticky #(
  parameter int unsigned W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] flags_o
);
  for (genvar i = 0; i < W; i++) begin : g_flag
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       bit_q <= 1'b0;
      else if (clr_i)    bit_q <= 1'b0;   // write clears, wins over set
      else if (set_i[i]) bit_q <= 1'b1;
    end
    assign flags_o[i] = bit_q;
  end
endmodule

// File: rtl/fpsr_core.sv
`timescale 1ns/1ps
module fpsr_core
  import fpsr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic              cmp_i,
  input  logic [COND_W-1:0] cond_i,
  output logic [REG_W-1:0]  base_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [STR_W-1:0]  stride_o
);
  logic [REG_W-1:0] base_q;
  logic [LEN_W-1:0] len_q;
  logic [STR_W-1:0] stride_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q   <= '0;
      len_q    <= '0;
      stride_q <= '0;
    end else if (wr_i) begin
      base_q   <= wr_data_i & WR_MASK;
      len_q    <= wr_data_i[LEN_LSB +: LEN_W];
      stride_q <= wr_data_i[STR_LSB +: STR_W];
    end else if (cmp_i) begin
      base_q[COND_LSB +: COND_W] <= cond_i;
    end
  end

  assign base_o   = base_q;
  assign len_o    = len_q;
  assign stride_o = stride_q;
endmodule

// File: rtl/fpsr_rd_mux.sv
`timescale 1ns/1ps
module fpsr_rd_mux
  import fpsr_pkg::*;
#(
  parameter logic [31:0] IDENT_VAL = 32'h4102_1000
) (
  input  logic [1:0]       sel_i,
  input  logic [REG_W-1:0] base_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [STR_W-1:0] stride_i,
  input  logic [EXC_W-1:0] flags_i,
  output logic [REG_W-1:0] data_o
);
  logic [REG_W-1:0] view;
  rd_sel_e          sel;

  assign sel = rd_sel_e'(sel_i);

  always_comb begin
    view = base_i;
    view[LEN_LSB +: LEN_W] = len_i;
    view[STR_LSB +: STR_W] = stride_i;
    view[EXC_W-1:0]        = base_i[EXC_W-1:0] | flags_i;
  end

  always_comb begin
    unique case (sel)
      RD_IDENT: data_o = IDENT_VAL;
      RD_CTRL:  data_o = view;
      RD_COND:  data_o = base_i & COND_MASK;
      default:  data_o = '0;
    endcase
  end
endmodule

// File: rtl/fpsr_ctrl.sv
`timescale 1ns/1ps
module fpsr_ctrl
  import fpsr_pkg::*;
#(
  parameter logic [31:0] IDENT_VAL = 32'h4102_1000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic        wr_sel_i,
  input  logic [31:0] wr_data_i,
  input  logic [1:0]  rd_sel_i,
  output logic [31:0] rd_data_o,
  input  logic [4:0]  exc_set_i,
  input  logic        cmp_valid_i,
  input  logic [1:0]  cmp_res_i,
  output logic [1:0]  round_mode_o,
  output logic [4:0]  trap_en_o,
  output logic [2:0]  vec_len_o,
  output logic [1:0]  vec_stride_o
);
  logic              wr_ctrl;
  logic [COND_W-1:0] cond;
  logic [REG_W-1:0]  base_q;
  logic [LEN_W-1:0]  len_q;
  logic [STR_W-1:0]  stride_q;
  logic [EXC_W-1:0]  sticky_q;

  // identification target has no storage; its writes fall away here
  assign wr_ctrl = wr_en_i & wr_sel_i;

  fpsr_cond_enc u_cond_enc (
    .res_i  (cmp_res_i),
    .cond_o (cond)
  );

  fpsr_core u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_ctrl),
    .wr_data_i (wr_data_i),
    .cmp_i     (cmp_valid_i),
    .cond_i    (cond),
    .base_o    (base_q),
    .len_o     (len_q),
    .stride_o  (stride_q)
  );

  fpsr_sticky #(.W(EXC_W)) u_sticky (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (wr_ctrl),
    .set_i   (exc_set_i),
    .flags_o (sticky_q)
  );

  fpsr_rd_mux #(.IDENT_VAL(IDENT_VAL)) u_rd_mux (
    .sel_i    (rd_sel_i),
    .base_i   (base_q),
    .len_i    (len_q),
    .stride_i (stride_q),
    .flags_i  (sticky_q),
    .data_o   (rd_data_o)
  );

  assign round_mode_o = base_q[RM_LSB +: RM_W];
  assign trap_en_o    = base_q[TRAP_LSB +: EXC_W];
  assign vec_len_o    = len_q;
  assign vec_stride_o = stride_q;
endmodule

// File: rtl/fpsr_ctrl_chk.sv
`timescale 1ns/1ps
module fpsr_ctrl_chk
  import fpsr_pkg::*;
#(
  parameter logic [31:0] IDENT_VAL = 32'h4102_1000
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic        wr_sel_i,
  input logic [31:0] wr_data_i,
  input logic [1:0]  rd_sel_i,
  input logic [31:0] rd_data_o,
  input logic [4:0]  exc_set_i,
  input logic        cmp_valid_i,
  input logic [1:0]  cmp_res_i,
  input logic [1:0]  round_mode_o,
  input logic [2:0]  vec_len_o,
  input logic [1:0]  vec_stride_o,
  input logic [31:0] base_q,
  input logic [4:0]  sticky_q
);
  logic wr_ctrl;
  assign wr_ctrl = wr_en_i && wr_sel_i;

  // R2
  field_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl |=> vec_len_o == $past(wr_data_i[18:16]) && vec_stride_o == $past(wr_data_i[21:20]));

  // R4
  round_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl |=> round_mode_o == $past(wr_data_i[23:22]));

  // R6
  sticky_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_ctrl && |exc_set_i) |=> (sticky_q & $past(exc_set_i)) == $past(exc_set_i));

  // R7
  cmp_keep_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_valid_i && !wr_ctrl) |=> base_q[27:0] == $past(base_q[27:0]));

  // R7
  cmp_eq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_valid_i && !wr_ctrl && cmp_res_i == 2'd0) |=> base_q[31:28] == 4'b1100);

  // R7
  cmp_un_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_valid_i && !wr_ctrl && cmp_res_i == 2'd3) |=> base_q[31:28] == 4'b0011);

  // R8
  cond_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_sel_i == 2'd2 |-> rd_data_o[27:0] == 28'd0);

  // R9
  ident_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_sel_i && !cmp_valid_i) |=> $stable(base_q) && $stable(vec_len_o));

  // R9
  ident_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_sel_i == 2'd0 |-> rd_data_o == IDENT_VAL);

  // R10
  write_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl && (cmp_valid_i || |exc_set_i)) |=>
      base_q == ($past(wr_data_i) & 32'hFFC8_FFFF) && sticky_q == 5'd0);
endmodule

bind fpsr_ctrl fpsr_ctrl_chk #(.IDENT_VAL(IDENT_VAL)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .wr_sel_i     (wr_sel_i),
  .wr_data_i    (wr_data_i),
  .rd_sel_i     (rd_sel_i),
  .rd_data_o    (rd_data_o),
  .exc_set_i    (exc_set_i),
  .cmp_valid_i  (cmp_valid_i),
  .cmp_res_i    (cmp_res_i),
  .round_mode_o (round_mode_o),
  .vec_len_o    (vec_len_o),
  .vec_stride_o (vec_stride_o),
  .base_q       (base_q),
  .sticky_q     (sticky_q)
);

// File: tb/fpsr_ctrl_tb.sv
`timescale 1ns/1ps
module fpsr_ctrl_tb;
  localparam logic [31:0] IDENT = 32'h5A10_0C31;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = 2'd0;
  logic [31:0] rd_data;
  logic [4:0]  exc_set = '0;
  logic        cmp_valid = 1'b0;
  logic [1:0]  cmp_res = '0;
  logic [1:0]  round_mode;
  logic [4:0]  trap_en;
  logic [2:0]  vec_len;
  logic [1:0]  vec_stride;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fpsr_ctrl #(.IDENT_VAL(IDENT)) u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .wr_en_i      (wr_en),
    .wr_sel_i     (wr_sel),
    .wr_data_i    (wr_data),
    .rd_sel_i     (rd_sel),
    .rd_data_o    (rd_data),
    .exc_set_i    (exc_set),
    .cmp_valid_i  (cmp_valid),
    .cmp_res_i    (cmp_res),
    .round_mode_o (round_mode),
    .trap_en_o    (trap_en),
    .vec_len_o    (vec_len),
    .vec_stride_o (vec_stride)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  // one clock with the given stimulus; returns at the following negedge
  task automatic drive(input logic we, input logic ws, input logic [31:0] d,
                       input logic cv, input logic [1:0] cr, input logic [4:0] ex);
    wr_en = we; wr_sel = ws; wr_data = d;
    cmp_valid = cv; cmp_res = cr; exc_set = ex;
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
    cmp_valid = 1'b0; cmp_res = '0; exc_set = '0;
  endtask

  task automatic read(input logic [1:0] sel, output logic [31:0] v);
    rd_sel = sel;
    #1;
    v = rd_data;
  endtask

  function automatic logic [3:0] cond_of(input int r);
    case (r)
      0: return 4'b1100;
      1: return 4'b1000;
      2: return 4'b0010;
      default: return 4'b0011;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] d;
    logic [4:0]  acc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    read(2'd1, v); check("R1 ctrl", v, 32'h0);
    read(2'd2, v); check("R1 cond", v, 32'h0);
    check("R1 fields", {20'd0, round_mode, trap_en, vec_len, vec_stride}, 32'h0);

    // R2 R3 R4 R5 sweep of all length/stride/rounding combinations
    for (int k = 0; k < 128; k++) begin
      d = 32'hA5C3_5A3C ^ (k * 32'h0103_0517);
      d[18:16] = k[2:0];
      d[21:20] = k[4:3];
      d[23:22] = k[6:5];
      drive(1'b1, 1'b1, d, 1'b0, 2'd0, 5'd0);
      read(2'd1, v);
      check("R3 ctrl readback", v, (d & 32'hFFC8FFFF) | (32'(k[2:0]) << 16) | (32'(k[4:3]) << 20));
      check("R2 vec_len", 32'(vec_len), 32'(k[2:0]));
      check("R2 vec_stride", 32'(vec_stride), 32'(k[4:3]));
      check("R4 round_mode", 32'(round_mode), 32'(k[6:5]));
      check("R5 trap_en", 32'(trap_en), 32'(d[12:8]));
    end

    // R6 sticky flags, every pattern, accumulate and clear
    for (int p = 1; p < 32; p++) begin
      drive(1'b1, 1'b1, 32'h0, 1'b0, 2'd0, 5'd0);
      drive(1'b0, 1'b0, 32'h0, 1'b0, 2'd0, 5'(p));
      drive(1'b0, 1'b0, 32'h0, 1'b0, 2'd0, 5'd0);
      read(2'd1, v); check("R6 sticky hold", v, 32'(p));
      acc = 5'(p) | 5'((p * 7) & 31);
      drive(1'b0, 1'b0, 32'h0, 1'b0, 2'd0, 5'((p * 7) & 31));
      read(2'd1, v); check("R6 sticky accumulate", v, 32'(acc));
    end
    drive(1'b1, 1'b1, 32'h0, 1'b0, 2'd0, 5'd0);
    read(2'd1, v); check("R6 cleared by write", v, 32'h0);

    // R7 R8 compare outcomes over a known word
    d = 32'h0ACE_3B1E;
    drive(1'b1, 1'b1, d, 1'b0, 2'd0, 5'd0);
    for (int r = 0; r < 4; r++) begin
      drive(1'b0, 1'b0, 32'h0, 1'b1, 2'(r), 5'd0);
      read(2'd1, v); check("R7 compare word", v, {cond_of(r), d[27:0]});
      read(2'd2, v); check("R8 cond read", v, {cond_of(r), 28'd0});
      check("R7 fields kept", {vec_len, vec_stride, round_mode}, {d[18:16], d[21:20], d[23:22]});
    end

    // R10 write wins over compare and flag pulse
    d = 32'h3F4C_1E07;
    drive(1'b0, 1'b0, 32'h0, 1'b0, 2'd0, 5'h1F);
    drive(1'b1, 1'b1, d, 1'b1, 2'd0, 5'h1F);
    read(2'd1, v); check("R10 write over cmp/flags", v, d);
    read(2'd2, v); check("R10 cond from write", v, {d[31:28], 28'd0});

    // R9 identification read and ignored write
    read(2'd0, v); check("R9 ident", v, IDENT);
    drive(1'b1, 1'b0, 32'hFFFF_FFFF, 1'b0, 2'd0, 5'd0);
    read(2'd0, v); check("R9 ident after write", v, IDENT);
    read(2'd1, v); check("R9 ctrl untouched", v, d);
    check("R9 fields untouched", 32'({round_mode, trap_en}), 32'({d[23:22], d[12:8]}));

    // R11 unused read select
    read(2'd3, v); check("R11 none view", v, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule